// File: doc/BRIEF.md
# Sector Parity Checker and Single-Bit Repair Unit

This block closes the read path of a flash controller that protects each sector with a 24-bit row/column parity code. It receives the code that was recomputed while the sector streamed in and the code that had been stored with the sector. It compares the two, sorts the outcome into clean, corrected or uncorrectable, and pinpoints a single flipped data bit by byte index and bit. When the flipped bit lies in the data, the unit repairs the sector buffer itself. It reads the addressed byte, XORs a one-hot mask into it and writes it back.

The two codes come in one of two forms, chosen by a mode input. The first form is a pair of 32-bit parity register images. Each image holds two 12-bit parity halves, with four unused bits above each half. The block squeezes out the unused bits and inverts the result, so a blank page of all-ones data matches its all-ones stored code. The second form is a pair of ready-made 24-bit codes. The block distinguishes a flipped data bit from a flipped parity bit. A data-bit error leaves the two 12-bit halves of the difference exact complements of each other. A parity-bit error leaves exactly one difference bit set.

Top module: `ecc_sector_fix`

## Requirements
- R1: After a synchronous active-low reset, `done`, `mem_rd` and `mem_we` are low and `status` reads 0 (clean).
- R2: When `raw_mode` is 1, each 32-bit input is reduced to a 24-bit code, with bits [11:0] forming code bits [11:0] and bits [27:16] forming code bits [23:12]. The reduced value is then inverted. Input bits [31:28] and [15:12] have no effect on any output. Two all-zero images therefore yield a clean result.
- R3: When `raw_mode` is 0, input bits [23:0] are taken as the code directly. The first stored byte sits in bits [7:0] and the third in bits [23:16].
- R4: The difference is the XOR of the recomputed and stored codes. A zero difference gives status 0 (clean) with no buffer access, and `done` is high in the first cycle after the accepting edge.
- R5: A nonzero difference whose bits [23:12] XOR bits [11:0] equal 0xFFF is a data-bit error. Its byte index is difference bits [23:15] and its bit number is difference bits [14:12]. For an index below SECTOR_BYTES, the status is 1 (corrected), `err_byte` shows the index and `err_mask` equals 1 shifted left by the bit number.
- R6: A data-bit error whose index is SECTOR_BYTES or more gives status 2 (uncorrectable), with zero byte and mask and no buffer access.
- R7: A repair asserts `mem_rd` with `mem_addr` equal to the index for one cycle. `mem_rdata` returns on the next cycle. In that cycle `mem_we` is high with `mem_wdata = mem_rdata ^ err_mask`. `done` follows in the next cycle, which is the third cycle after the accepting edge.
- R8: A difference with exactly one bit set gives status 1 with zero mask and no buffer access.
- R9: Any other nonzero difference gives status 2 with no buffer access.
- R10: `done` is a one-cycle pulse, and status, byte and mask hold their values while it is high. A `start` raised during the `done` cycle is accepted at once.
- R11: A `start` raised while a repair read or write is in progress is ignored. It does not alter that repair or its result, and it produces no later `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a new comparison |
| raw_mode | input | 1 | 1: inputs are 32-bit parity images; 0: inputs are 24-bit codes |
| calc_in | input | 32 | Recomputed parity (image or code) |
| stored_in | input | 32 | Stored parity (image or code) |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_byte | output | 9 | Byte index of a repaired data bit |
| err_mask | output | 8 | One-hot mask of the repaired bit |
| mem_rd | output | 1 | Buffer read request |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Repaired byte |
| mem_rdata | input | 8 | Buffer read data, one cycle after `mem_rd` |

## Verification
Two functions of this block can fall in the same cycle. One is the result strobe of one comparison. The other is the acceptance of the next `start`, which lands exactly in that strobe cycle. The bench provokes this on almost every request, because each request is launched at the very sample where the previous `done` was seen high. Every result is then judged against an arithmetic model of the difference code, together with its own latency and its own count of buffer writes. This shows that neither the outgoing result nor the incoming request steals from the other. A separate case raises `start` in the middle of a repair read. It then checks that the repair completes unchanged and that no extra strobe follows.

// File: rtl/ecc_fix_pkg.sv
// Shared types and helpers for the sector parity checker.
// Assumes a 24-bit code built from two 12-bit halves; byte index is 9 bits.
package ecc_fix_pkg;
    localparam int CODE_W = 24;
    localparam int HALF_W = CODE_W / 2;
    localparam int BIT_W  = 3;
    localparam int IDX_W  = HALF_W - BIT_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e      status;
        logic             fix;
        logic [IDX_W-1:0] idx;
        logic [7:0]       mask;
    } ecc_verdict_t;

    // Squeeze the unused nibbles out of a parity image and invert it.
    function automatic logic [CODE_W-1:0] pack_raw(input logic [31:0] img);
        return ~{img[16 +: HALF_W], img[0 +: HALF_W]};
    endfunction
endpackage

// File: rtl/ecc_code_pack.sv
// Turns one parity input into a 24-bit code.
// Assumes raw_mode selects image reduction; otherwise the low 24 bits pass through.
module ecc_code_pack
    import ecc_fix_pkg::*;
(
    input  logic              raw_mode,
    input  logic [31:0]       src,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] packed_img;

    // Reduce the image form.
    always_comb packed_img = pack_raw(src);

    // Pick the form chosen by the mode input.
    always_comb code = raw_mode ? packed_img : src[CODE_W-1:0];
endmodule

// File: rtl/ecc_classify.sv
// Compares two 24-bit codes and classifies the difference.
// Purely combinational; assumes SECTOR_BYTES does not exceed 2**IDX_W.
module ecc_classify
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output ecc_verdict_t      verdict
);
    logic [CODE_W-1:0] diff;
    logic              complement;
    logic [IDX_W-1:0]  idx;
    logic [BIT_W-1:0]  bitno;
    logic              in_range;

    // Difference and its fields.
    always_comb begin
        diff       = calc_code ^ stored_code;
        complement = (diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}};
        idx        = diff[CODE_W-1 -: IDX_W];
        bitno      = diff[HALF_W +: BIT_W];
        in_range   = 32'(idx) < SECTOR_BYTES;
    end

    // Sort the outcome into clean, corrected or uncorrectable.
    always_comb begin
        verdict        = '0;
        verdict.status = ST_CLEAN;
        if (diff != '0) begin
            if (complement) begin
                if (in_range) begin
                    verdict.status = ST_FIXED;
                    verdict.fix    = 1'b1;
                    verdict.idx    = idx;
                    verdict.mask   = 8'(1) << bitno;
                end else begin
                    verdict.status = ST_BAD;
                end
            end else if ($onehot(diff)) begin
                verdict.status = ST_FIXED;
            end else begin
                verdict.status = ST_BAD;
            end
        end
    end
endmodule

// File: rtl/ecc_fix_seq.sv
// Sequencer: latches a verdict, runs the read-modify-write repair and strobes done.
// Assumes the buffer returns read data one cycle after a read request.
module ecc_fix_seq
    import ecc_fix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ecc_verdict_t     verdict_i,
    output logic             done,
    output logic [1:0]       status,
    output logic [IDX_W-1:0] err_byte,
    output logic [7:0]       err_mask,
    output logic             mem_rd,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} seq_state_e;

    seq_state_e       state_q;
    ecc_status_e      status_q;
    logic [IDX_W-1:0] byte_q;
    logic [7:0]       mask_q;
    logic             accept;

    // A request is taken when idle or in the strobe cycle.
    always_comb accept = start && (state_q == S_IDLE || state_q == S_FIN);

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_CLEAN;
            byte_q   <= '0;
            mask_q   <= '0;
        end else if (accept) begin
            status_q <= verdict_i.status;
            byte_q   <= verdict_i.idx;
            mask_q   <= verdict_i.mask;
            state_q  <= verdict_i.fix ? S_RD : S_FIN;
        end else begin
            case (state_q)
                S_RD:    state_q <= S_WR;
                S_WR:    state_q <= S_FIN;
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Port drive from state.
    always_comb begin
        done      = state_q == S_FIN;
        mem_rd    = state_q == S_RD;
        mem_we    = state_q == S_WR;
        mem_addr  = byte_q;
        mem_wdata = mem_rdata ^ mask_q;
        status    = status_q;
        err_byte  = byte_q;
        err_mask  = mask_q;
    end

    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_we);
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_rd));
    a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $countones(mem_wdata ^ mem_rdata) == 1);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ($stable(err_byte) && $stable(err_mask) && $stable(status)));
    a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);
endmodule

// File: rtl/ecc_sector_fix.sv
// Top: packs both parity inputs, classifies the difference and repairs the buffer.
// Assumes SECTOR_BYTES <= 512 and a buffer with one-cycle read latency.
module ecc_sector_fix
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             raw_mode,
    input  logic [31:0]      calc_in,
    input  logic [31:0]      stored_in,
    output logic             done,
    output logic [1:0]       status,
    output logic [IDX_W-1:0] err_byte,
    output logic [7:0]       err_mask,
    output logic             mem_rd,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam int NSRC = 2;

    logic [31:0]       src_in  [NSRC];
    logic [CODE_W-1:0] src_code[NSRC];
    ecc_verdict_t      verdict;

    // Gather both inputs for the packer array.
    always_comb begin
        src_in[0] = calc_in;
        src_in[1] = stored_in;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_pack
        ecc_code_pack u_pack (
            .raw_mode (raw_mode),
            .src      (src_in[g]),
            .code     (src_code[g])
        );
    end

    ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_class (
        .calc_code   (src_code[0]),
        .stored_code (src_code[1]),
        .verdict     (verdict)
    );

    ecc_fix_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .verdict_i (verdict),
        .done      (done),
        .status    (status),
        .err_byte  (err_byte),
        .err_mask  (err_mask),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> 32'(mem_addr) < SECTOR_BYTES);
    a_r8_parity_hit_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1 && err_mask == 8'd0) |-> !$past(mem_we));
endmodule

// File: tb/sim_ecc_sector_fix.sv
module sim_ecc_sector_fix;
    localparam int SEC = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        raw_mode = 1'b0;
    logic [31:0] calc_in = '0;
    logic [31:0] stored_in = '0;
    logic        done, mem_rd, mem_we;
    logic [1:0]  status;
    logic [8:0]  err_byte, mem_addr;
    logic [7:0]  err_mask, mem_wdata;
    logic [7:0]  rdq = '0;
    logic [7:0]  mem [0:511];
    int          wr_cnt = 0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    ecc_sector_fix #(.SECTOR_BYTES(SEC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_mode(raw_mode),
        .calc_in(calc_in), .stored_in(stored_in), .done(done), .status(status),
        .err_byte(err_byte), .err_mask(err_mask), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdq)
    );

    // Sector buffer model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) rdq <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] to_img(input logic [23:0] code, input logic [7:0] junk);
        logic [23:0] r;
        r = ~code;
        return {junk[7:4], r[23:12], junk[3:0], r[11:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    task automatic model(input logic [23:0] c, input logic [23:0] s,
                         output int st, output int idx, output int msk, output bit fix);
        logic [23:0] d;
        int ones;
        bit comp;
        d = c ^ s;
        st = 0; idx = 0; msk = 0; fix = 0;
        ones = 0;
        comp = 1;
        for (int k = 0; k < 24; k++) if (d[k]) ones++;
        for (int k = 0; k < 12; k++) if (d[k] == d[k+12]) comp = 0;
        if (ones == 0) st = 0;
        else if (comp) begin
            idx = int'(d) / 32768;
            if (idx < SEC) begin
                st = 1; fix = 1; msk = 1 << ((int'(d) / 4096) % 8);
            end else begin
                st = 2; idx = 0;
            end
        end else if (ones == 1) st = 1;
        else st = 2;
    endtask

    // Launch one comparison at a falling edge and judge its result.
    task automatic run(input bit raw, input logic [23:0] c, input logic [23:0] s,
                       input logic [7:0] junk, input string req);
        int st, idx, msk, lat, wc0;
        bit fix;
        model(c, s, st, idx, msk, fix);
        wc0 = wr_cnt;
        raw_mode = raw;
        calc_in = raw ? to_img(c, junk) : {junk, c};
        stored_in = raw ? to_img(s, ~junk) : {~junk, s};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        check(int'(status) == st, req, int'(status), st);
        check(lat == (fix ? 3 : 1), {req, "/R7 latency"}, lat, fix ? 3 : 1);
        if (fix) begin
            check(int'(err_byte) == idx && int'(err_mask) == msk, {req, "/R5 loc"},
                  int'(err_byte) * 256 + int'(err_mask), idx * 256 + msk);
            check(mem[idx] == (pat(idx) ^ 8'(msk)) && wr_cnt - wc0 == 1, {req, "/R7 rmw"},
                  int'(mem[idx]), int'(pat(idx) ^ 8'(msk)));
            mem[idx] = pat(idx);
        end else begin
            check(wr_cnt == wc0, {req, "/R9 no write"}, wr_cnt - wc0, 0);
            if (st == 1)
                check(err_mask == 8'd0, {req, "/R8 mask"}, int'(err_mask), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        check(!done && !mem_rd && !mem_we && status == 2'd0, "R1", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && status == 2'd0, "R1", int'(status), 0);

        // R4 clean, R2 erased page and reserved bits, R3 code form
        run(1'b0, 24'h123456, 24'h123456, 8'h5A, "R4");
        run(1'b1, 24'hFFFFFF, 24'hFFFFFF, 8'hC3, "R2");
        run(1'b1, 24'hA5C3E1, 24'hA5C3E1, 8'hF0, "R2");
        run(1'b0, 24'h00FF00, 24'h00FF00, 8'h00, "R3");

        // R8 every single-bit difference
        for (int b = 0; b < 24; b++)
            run(b % 2 == 1, 24'h3C5A96, 24'h3C5A96 ^ (24'h1 << b), 8'(b * 9), "R8");

        // R9 multi-bit differences
        run(1'b0, 24'h000000, 24'h000003, 8'h11, "R9");
        run(1'b1, 24'h000000, 24'hFFF7FF, 8'h22, "R9");
        run(1'b0, 24'h123456, 24'hEDCBA8, 8'h33, "R9");

        // R5 R6 R7 sweep of every data-bit location, back-to-back launches (R10)
        for (int ix = 0; ix < 512; ix++) begin
            for (int bt = 0; bt < 8; bt++) begin
                logic [11:0] up;
                logic [23:0] d, c;
                up = 12'(ix * 8 + bt);
                d = {up, ~up};
                c = 24'((ix * 40503 + bt * 977) & 24'hFFFFFF);
                run((ix + bt) % 2 == 1, c, c ^ d, 8'(ix + bt), ix < SEC ? "R5" : "R6");
            end
            if (ix % 64 == 0) @(negedge clk);
        end

        // R10 strobe lasts one cycle when no new start follows
        run(1'b0, 24'h0F0F0F, 24'h0F0F0F, 8'h00, "R10");
        @(negedge clk);
        check(!done, "R10 pulse", int'(done), 0);

        // R11 start during a repair is ignored
        begin
            int lat;
            raw_mode = 1'b0;
            calc_in = 32'h0;
            stored_in = {8'h0, 12'(5 * 8 + 2), ~12'(5 * 8 + 2)};
            start = 1'b1;
            @(negedge clk);
            calc_in = 32'h0;
            stored_in = 32'h0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 2;
            while (!done && lat < 12) begin
                @(negedge clk);
                lat++;
            end
            check(lat == 3 && status == 2'd1, "R11 result", lat, 3);
            check(err_byte == 9'd5 && err_mask == 8'h04, "R11 loc",
                  int'(err_byte) * 256 + int'(err_mask), 5 * 256 + 4);
            check(mem[5] == (pat(5) ^ 8'h04), "R11 rmw", int'(mem[5]), int'(pat(5) ^ 8'h04));
            mem[5] = pat(5);
            @(negedge clk);
            check(!done, "R11 no extra done", int'(done), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule